// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block is a serial port that moves one byte at a time as a plain synchronous shift register over two pins. The clock pin is always driven by the block. It idles high, and during a transfer it makes one high-then-low cycle per bit. The data pin is shared. The block drives it while transmitting and when idle, and releases it while receiving. Bits travel least significant first in both directions.

Software controls the port through a small register interface with two addresses. Address 0 is the control register. Address 1 is the data register: a write loads a byte for transmission, and a read returns the last received byte.

The control register holds these fields:
- bits [7:6]: the mode field;
- bit 4: the receive-enable bit;
- bit 1: the transmit-done flag;
- bit 0: the receive-done flag.

The other control bits read as 0. Transfers happen only when the mode field is 00.

A write to the data register in that mode starts a transmit. A receive starts on its own when the receive-enable bit is 1 and the receive-done flag is 0. The shift-clock period is `CLK_DIV` system clocks, split evenly between the high and low phases.

The controller has five states:
- `ST_IDLE`: no transfer is active.
- `ST_TX_HI` and `ST_TX_LO`: the high and low clock phases of a transmit.
- `ST_RX_HI` and `ST_RX_LO`: the high and low clock phases of a receive.

It makes these transitions:
- IDLE to TX_HI on a transmit start.
- IDLE to RX_HI on a receive start.
- Each HI state goes to its LO state at the end of the high phase.
- Each LO state goes back to its HI state at the end of a low phase for bits 0 to 6.
- Each LO state goes to IDLE at the end of the low phase of bit 7.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the clock pin is high, the data pin is driven (`sdata_oe`=1) with value 1, and both register addresses read 0x00.
- R2: A write to address 1 while idle with mode 00 starts a transmit on the same clock edge. The transmitted byte is placed on `sdata_o` least significant bit first, and each bit is held for `CLK_DIV` cycles.
- R3: During a transfer, each bit period has the clock pin high for `CLK_DIV/2` cycles and then low for `CLK_DIV/2` cycles. When no transfer is active, the clock pin stays high.
- R4: After the low phase of the eighth bit, the data pin is driven high and the transmit-done flag (control bit 1) is set on the same edge.
- R5: A receive starts on the edge after the block is idle with mode 00, receive-enable (bit 4) set and receive-done (bit 0) clear. For the whole receive, `sdata_oe` is 0.
- R6: While receiving, `sdata_i` is sampled on the last cycle of each low phase and shifted in least significant bit first. After eight samples, the receive-done flag is set and address 1 returns the received byte.
- R7: The two done flags are cleared only by writing 0 to their bit in the control register. Writing 1 leaves a flag unchanged, and when a hardware set and a clearing write fall on the same edge, the set wins.
- R8: No receive starts while the receive-done flag is set.
- R9: When the mode field is not 00, a data write starts no transmit and no receive starts.
- R10: A write to address 1 during an active transfer is ignored.
- R11: A read of address 1 returns the last received byte, never the byte being transmitted.
- R12: If a transmit start and a receive start fall on the same edge, the transmit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sclk_o | output | 1 | Shift clock pin |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Data pin input value |

## Verification
The assertions assume the following about the inputs:
- Register writes are single-cycle strobes on the system clock.
- `sdata_i` is stable around the sampling edge of each low phase.
- `CLK_DIV` is even and at least 2.

The stimulus writes registers with one-cycle strobes only. It changes `sdata_i` a short delay after a clock edge, and for a whole bit period at a time. It keeps the default divider of 12 throughout.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_HI,
        ST_TX_LO,
        ST_RX_HI,
        ST_RX_LO
    } ssp_state_e;

    localparam logic [1:0] MODE_SHIFT = 2'b00;
    localparam int CTL_MODE_LSB = 6;
    localparam int CTL_RXEN     = 4;
    localparam int CTL_TXDONE   = 1;
    localparam int CTL_RXDONE   = 0;
endpackage

// File: rtl/ssp_divider.sv
module ssp_divider #(
    parameter int HALF = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ph_last
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign ph_last = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || ph_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
    import ssp_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_go,
    input  logic rx_go,
    input  logic ph_last,
    output logic idle,
    output logic sclk_o,
    output logic drive_o,
    output logic tx_on,
    output logic tx_shift,
    output logic rx_sample,
    output logic tx_done,
    output logic rx_done
);
    localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

    ssp_state_e state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          last_bit;

    assign last_bit = (bit_q == BW'(BITS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_go) state_d = ST_TX_HI;
                      else if (rx_go) state_d = ST_RX_HI;
            ST_TX_HI: if (ph_last) state_d = ST_TX_LO;
            ST_TX_LO: if (ph_last) state_d = last_bit ? ST_IDLE : ST_TX_HI;
            ST_RX_HI: if (ph_last) state_d = ST_RX_LO;
            ST_RX_LO: if (ph_last) state_d = last_bit ? ST_IDLE : ST_RX_HI;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                bit_q <= '0;
            end else if (ph_last && (state_q == ST_TX_LO || state_q == ST_RX_LO)) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        sclk_o    = !(state_q == ST_TX_LO || state_q == ST_RX_LO);
        drive_o   = !(state_q == ST_RX_HI || state_q == ST_RX_LO);
        tx_on     = (state_q == ST_TX_HI || state_q == ST_TX_LO);
        tx_shift  = ph_last && (state_q == ST_TX_LO);
        rx_sample = ph_last && (state_q == ST_RX_LO);
        tx_done   = tx_shift && last_bit;
        rx_done   = rx_sample && last_bit;
    end

    // R3: a busy state is left only when the divider marks a phase end
    assert_phase_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != $past(state_q)) && ($past(state_q) != ST_IDLE)) |-> $past(ph_last));

    // R2: a transfer ends only after its final bit
    assert_eight_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && ($past(state_q) == ST_TX_LO || $past(state_q) == ST_RX_LO))
        |-> ($past(bit_q) == BW'(BITS - 1)));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tx_shift,
    input  logic         rx_sample,
    input  logic         rx_done,
    input  logic         sdi,
    output logic         tx_bit,
    output logic [W-1:0] rx_data
);
    logic [W-1:0] tx_q, rx_q, rx_buf_q, rx_next;

    assign rx_next = {sdi, rx_q[W-1:1]};
    assign tx_bit  = tx_q[0];
    assign rx_data = rx_buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rx_q     <= '0;
            rx_buf_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_data;
            end else if (tx_shift) begin
                tx_q <= {1'b0, tx_q[W-1:1]};
            end
            if (rx_sample) rx_q <= rx_next;
            if (rx_done)   rx_buf_q <= rx_next;
        end
    end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe,
    input  logic              sdata_i
);
    localparam int HALF = CLK_DIV / 2;

    logic [1:0] mode_q;
    logic       rx_en_q, ti_q, ri_q;
    logic       ctl_wr, dat_wr, tx_go, rx_go;
    logic       idle, ph_last, tx_on, tx_bit;
    logic       tx_shift, rx_sample, tx_done, rx_done;
    logic [DATA_W-1:0] rx_data, ctl_view;
    logic       unused_wbits;

    assign ctl_wr = bus_sel && bus_wr && !bus_addr;
    assign dat_wr = bus_sel && bus_wr &&  bus_addr;
    assign tx_go  = dat_wr && idle && (mode_q == MODE_SHIFT);
    assign rx_go  = idle && (mode_q == MODE_SHIFT) && rx_en_q && !ri_q && !tx_go;
    assign unused_wbits = ^{bus_wdata[DATA_W-1:CTL_MODE_LSB+2], bus_wdata[5], bus_wdata[3:2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SHIFT;
            rx_en_q <= 1'b0;
            ti_q    <= 1'b0;
            ri_q    <= 1'b0;
        end else begin
            if (ctl_wr) begin
                mode_q  <= bus_wdata[CTL_MODE_LSB +: 2];
                rx_en_q <= bus_wdata[CTL_RXEN];
                ti_q    <= tx_done || (ti_q && bus_wdata[CTL_TXDONE]);
                ri_q    <= rx_done || (ri_q && bus_wdata[CTL_RXDONE]);
            end else begin
                ti_q <= ti_q || tx_done;
                ri_q <= ri_q || rx_done;
            end
        end
    end

    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_MODE_LSB +: 2] = mode_q;
        ctl_view[CTL_RXEN]          = rx_en_q;
        ctl_view[CTL_TXDONE]        = ti_q;
        ctl_view[CTL_RXDONE]        = ri_q;
        bus_rdata = bus_addr ? rx_data : ctl_view;
        sdata_o   = tx_on ? tx_bit : 1'b1;
    end

    ssp_divider #(.HALF(HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!idle), .ph_last(ph_last)
    );

    ssp_fsm #(.BITS(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .rx_go(rx_go), .ph_last(ph_last),
        .idle(idle), .sclk_o(sclk_o), .drive_o(sdata_oe), .tx_on(tx_on),
        .tx_shift(tx_shift), .rx_sample(rx_sample), .tx_done(tx_done), .rx_done(rx_done)
    );

    ssp_shifter #(.W(DATA_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .load(tx_go), .load_data(bus_wdata),
        .tx_shift(tx_shift), .rx_sample(rx_sample), .rx_done(rx_done), .sdi(sdata_i),
        .tx_bit(tx_bit), .rx_data(rx_data)
    );

    // R5 and R8: a receive begins only from mode 00, enabled, with the done flag clear
    assert_rx_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe) |-> $past(!ri_q && rx_en_q && mode_q == MODE_SHIFT));

    // R7: transmit-done falls only on a control write with that bit at 0
    assert_ti_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ti_q) |-> $past(ctl_wr && !bus_wdata[CTL_TXDONE]));

    // R7: receive-done falls only on a control write with that bit at 0
    assert_ri_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ri_q) |-> $past(ctl_wr && !bus_wdata[CTL_RXDONE]));

    // R4: the data pin is driven high whenever the block is not busy
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (sdata_oe && sdata_o));
endmodule

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
    localparam int DIV  = 12;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk_o, sdata_o, sdata_oe;
    logic       sdata_i = 1'b0;

    int vectors = 0;
    int fails = 0;

    // reference model state
    int         m_busy = 0;   // 0 idle, 1 transmit, 2 receive
    int         m_k = 0;
    logic [7:0] m_tx = 0, m_acc = 0, m_rxbuf = 0;
    logic [1:0] m_mode = 0;
    logic       m_rxen = 0, m_ti = 0, m_ri = 0;
    logic [7:0] rx_pat = 8'h00;

    always #10 clk = ~clk;

    sync_shift_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i)
    );

    always @(posedge clk) begin
        int         p_busy;
        logic [1:0] p_mode;
        logic       p_rxen, p_ri, hw_ti, hw_ri;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_tx = 0; m_acc = 0; m_rxbuf = 0;
            m_mode = 0; m_rxen = 0; m_ti = 0; m_ri = 0;
        end else begin
            p_busy = m_busy; p_mode = m_mode; p_rxen = m_rxen; p_ri = m_ri;
            hw_ti = 0; hw_ri = 0;
            if (m_busy != 0) begin
                if (m_busy == 2 && (m_k % DIV) == DIV - 1) m_acc[m_k / DIV] = sdata_i;
                if (m_k == 8 * DIV - 1) begin
                    if (m_busy == 1) hw_ti = 1;
                    else begin hw_ri = 1; m_rxbuf = m_acc; end
                    m_busy = 0;
                end else begin
                    m_k++;
                end
            end
            if (bus_sel && bus_wr && !bus_addr) begin
                m_mode = bus_wdata[7:6];
                m_rxen = bus_wdata[4];
                m_ti   = m_ti & bus_wdata[1];
                m_ri   = m_ri & bus_wdata[0];
            end
            if (bus_sel && bus_wr && bus_addr && p_busy == 0 && p_mode == 2'b00) begin
                m_busy = 1; m_k = 0; m_tx = bus_wdata;          // R2, R12
            end else if (p_busy == 0 && p_mode == 2'b00 && p_rxen && !p_ri) begin
                m_busy = 2; m_k = 0;                            // R5, R8
            end
            if (hw_ti) m_ti = 1;
            if (hw_ri) m_ri = 1;
        end
    end

    // external device: presents receive bits, noise otherwise
    always @(posedge clk) begin
        #2;
        if (m_busy == 2) sdata_i = rx_pat[m_k / DIV];
        else             sdata_i = ~sdata_i;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] e_rd;
        if (rst_n) begin
            vectors++;
            chk("R3 sclk", {7'd0, sclk_o}, {7'd0, (m_busy == 0) ? 1'b1 : ((m_k % DIV) < HALF)});
            chk("R5 oe", {7'd0, sdata_oe}, {7'd0, m_busy != 2});
            if (m_busy != 2)
                chk("R2/R4 data", {7'd0, sdata_o}, {7'd0, (m_busy == 1) ? m_tx[m_k / DIV] : 1'b1});
            e_rd = bus_addr ? m_rxbuf : {m_mode, 1'b0, m_rxen, 2'b00, m_ti, m_ri};
            chk("R6/R7/R11 rdata", bus_rdata, e_rd);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input string req, input logic a, input logic [7:0] exp);
        bus_addr = a;
        @(negedge clk); #1;
        vectors++;
        chk(req, bus_rdata, exp);
        cyc(1);
    endtask

    task automatic pin(input string req, input logic act, input logic exp);
        @(negedge clk); #1;
        vectors++;
        chk(req, {7'd0, act}, {7'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1;
        pin("R1 sclk", sclk_o, 1'b1);
        pin("R1 oe", sdata_oe, 1'b1);
        pin("R1 data", sdata_o, 1'b1);
        rd("R1 ctl", 1'b0, 8'h00);
        rd("R1 buf", 1'b1, 8'h00);

        wr(1'b1, 8'hA5);                    // R2 transmit
        cyc(100);
        rd("R4 ti", 1'b0, 8'h02);
        wr(1'b0, 8'h03);                    // R7 writing ones keeps flags
        rd("R7 keep", 1'b0, 8'h02);
        wr(1'b0, 8'h00);
        rd("R7 clear", 1'b0, 8'h00);

        rx_pat = 8'h3C;
        wr(1'b0, 8'h10);                    // R5 receive
        cyc(100);
        rd("R6 byte", 1'b1, 8'h3C);
        rd("R6 ri", 1'b0, 8'h11);
        cyc(30);
        pin("R8 no restart", sclk_o, 1'b1);

        wr(1'b1, 8'h5A);
        cyc(5);
        wr(1'b1, 8'hFF);                    // R10 ignored while busy
        cyc(100);
        rd("R11 buf", 1'b1, 8'h3C);
        rd("R4 ti2", 1'b0, 8'h13);

        rx_pat = 8'hC3;
        wr(1'b0, 8'h12);
        cyc(20);
        wr(1'b1, 8'h00);                    // R10 ignored during receive
        cyc(90);
        rd("R6 byte2", 1'b1, 8'hC3);

        wr(1'b0, 8'h40);                    // R9 mode 01
        wr(1'b1, 8'h77);
        cyc(20);
        pin("R9 no tx", sclk_o, 1'b1);
        wr(1'b0, 8'hD0);                    // R9 mode 11 with receive enabled
        cyc(20);
        pin("R9 no rx", sdata_oe, 1'b1);

        wr(1'b0, 8'h50);
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h81);                    // R12 same-edge start
        pin("R12 tx wins", sdata_oe, 1'b1);
        cyc(220);
        rd("R12 ti", 1'b0, 8'h13);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule